// File: doc/BRIEF.md
# Replicated Line Read Corrector

This block sits on the read path of a cache that can hold one, two or three copies of each line, depending on how much redundancy the supply voltage calls for. On a read it receives the stored copies of one line segment together with their per-partition parity bits. It produces one corrected segment, and for each 16-bit partition it also reports whether a fault was seen and whether the fault was left uncorrected. On the write side it computes the parity bits that are stored with every copy.

The redundancy mode selects how the copies are combined. In single mode, parity only detects faults. In double mode, the two copies are compared and parity picks the copy to use when they disagree. In triple mode, a bitwise majority vote is taken over the data and over the parity bits. If the voted word fails its parity check, the corrector falls back to the lowest-numbered copy whose parity holds. Each partition is handled on its own. The correction logic is purely combinational and sits in front of a single output register, so a result appears one clock after its inputs are sampled.

Top module: `rcc_top`

## Requirements
- R1: `wr_parity[k]` equals the XOR of the 16 bits `wr_data[16k+15:16k]` (even parity), for every partition k. The write parity is available combinationally.
- R2: Inputs sampled at a rising edge show on the outputs right after that edge. `out_valid` is high exactly when `in_valid` was high and `mode` was not 3. Reset clears all outputs to zero.
- R3: Mode 0 (single copy): each output partition equals copy 0. The error and uncorrectable flags are both set exactly when the recomputed parity of copy 0 differs from its stored bit.
- R4: Mode 1 (double copy), copies 0 and 1 equal in a partition: copy 0 is output with no flags. Copy 2 has no effect.
- R5: Mode 1, copies differ and exactly one of them passes parity: that copy is output, with error set and uncorrectable clear.
- R6: Mode 1, copies differ and both pass or both fail parity: error and uncorrectable are set, and copy 0 is output.
- R7: Mode 2 (triple copy), the voted data matches the voted parity bit: the voted data is output. Error is set exactly when the three copies (data or parity) are not all identical. Uncorrectable is clear.
- R8: Mode 2, the voted data fails parity: the lowest-numbered copy that passes parity is output, with error set and uncorrectable clear.
- R9: Mode 2, the voted data fails parity and no copy passes: error and uncorrectable are set, and the voted data is output.
- R10: Mode 3 (disabled) or `in_valid` low: `out_valid`, `out_data`, `out_err` and `out_uncorr` are all zero on the next cycle.
- R11: Partitions are corrected independently: a fault in one partition never changes another partition's data or flags, and an uncorrectable flag is never set without its error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Read copies present this cycle |
| mode | input | 2 | 0 single, 1 double, 2 triple, 3 disabled |
| copy0_data | input | NUM_PARTS*16 | Stored copy 0 |
| copy1_data | input | NUM_PARTS*16 | Stored copy 1 |
| copy2_data | input | NUM_PARTS*16 | Stored copy 2 |
| copy0_par | input | NUM_PARTS | Parity bits of copy 0 |
| copy1_par | input | NUM_PARTS | Parity bits of copy 1 |
| copy2_par | input | NUM_PARTS | Parity bits of copy 2 |
| wr_data | input | NUM_PARTS*16 | Segment being written |
| wr_parity | output | NUM_PARTS | Parity bits to store with each copy |
| out_valid | output | 1 | Corrected result valid |
| out_data | output | NUM_PARTS*16 | Corrected segment |
| out_err | output | NUM_PARTS | Fault seen in partition |
| out_uncorr | output | NUM_PARTS | Fault left uncorrected in partition |

## Verification
The clocked checks compare each output with the inputs of the previous cycle. They therefore assume `in_valid`, `mode` and the copies are held steady from a falling edge to the next rising edge, and that nothing is driven active while reset is high. The bench changes inputs only on falling edges and keeps `in_valid` low throughout reset. It also assumes that copies unused by the active mode may hold any value. The stimulus deliberately fills them with unrelated words, and every partition outside the faulted one carries all-zero copies with matching parity.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int PART_W = 16;

    typedef enum logic [1:0] {
        RC_SINGLE = 2'd0,
        RC_DOUBLE = 2'd1,
        RC_TRIPLE = 2'd2,
        RC_OFF    = 2'd3
    } rc_mode_e;

    typedef struct packed {
        logic [PART_W-1:0] data;
        logic              err;
        logic              unc;
    } rc_result_t;

    function automatic logic even_par(input logic [PART_W-1:0] w);
        return ^w;
    endfunction
endpackage

// File: rtl/rcc_wr_parity.sv
module rcc_wr_parity
    import rcc_pkg::*;
#(
    parameter int NUM_PARTS = 4,
    localparam int SEG_W = NUM_PARTS * PART_W
) (
    input  logic [SEG_W-1:0]     data_i,
    output logic [NUM_PARTS-1:0] par_o
);
    for (genvar k = 0; k < NUM_PARTS; k++) begin : g_par
        assign par_o[k] = even_par(data_i[k*PART_W +: PART_W]);
    end
endmodule

// File: rtl/rcc_part_corrector.sv
module rcc_part_corrector
    import rcc_pkg::*;
(
    input  rc_mode_e          mode_i,
    input  logic [PART_W-1:0] d0_i,
    input  logic [PART_W-1:0] d1_i,
    input  logic [PART_W-1:0] d2_i,
    input  logic              p0_i,
    input  logic              p1_i,
    input  logic              p2_i,
    output rc_result_t        res_o
);
    logic              ok0, ok1, ok2, vote_ok, same3, vp;
    logic [PART_W-1:0] vd;

    always_comb begin
        ok0     = (even_par(d0_i) == p0_i);
        ok1     = (even_par(d1_i) == p1_i);
        ok2     = (even_par(d2_i) == p2_i);
        vd      = (d0_i & d1_i) | (d0_i & d2_i) | (d1_i & d2_i);
        vp      = (p0_i & p1_i) | (p0_i & p2_i) | (p1_i & p2_i);
        vote_ok = (even_par(vd) == vp);
        same3   = (d0_i == d1_i) && (d1_i == d2_i) && (p0_i == p1_i) && (p1_i == p2_i);

        res_o.data = d0_i;
        res_o.err  = 1'b0;
        res_o.unc  = 1'b0;
        unique case (mode_i)
            RC_SINGLE: begin
                res_o.err = !ok0;
                res_o.unc = !ok0;
            end
            RC_DOUBLE: begin
                if (d0_i != d1_i) begin
                    res_o.err = 1'b1;
                    if (ok1 && !ok0)      res_o.data = d1_i;
                    else if (!(ok0 && !ok1)) res_o.unc = 1'b1;
                end
            end
            RC_TRIPLE: begin
                res_o.data = vd;
                if (vote_ok) begin
                    res_o.err = !same3;
                end else begin
                    res_o.err = 1'b1;
                    if (ok0)      res_o.data = d0_i;
                    else if (ok1) res_o.data = d1_i;
                    else if (ok2) res_o.data = d2_i;
                    else          res_o.unc  = 1'b1;
                end
            end
            default: res_o.data = '0;
        endcase
    end
endmodule

// File: rtl/rcc_top.sv
module rcc_top
    import rcc_pkg::*;
#(
    parameter int NUM_PARTS = 4,
    localparam int SEG_W = NUM_PARTS * PART_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic [SEG_W-1:0]     copy0_data,
    input  logic [SEG_W-1:0]     copy1_data,
    input  logic [SEG_W-1:0]     copy2_data,
    input  logic [NUM_PARTS-1:0] copy0_par,
    input  logic [NUM_PARTS-1:0] copy1_par,
    input  logic [NUM_PARTS-1:0] copy2_par,
    input  logic [SEG_W-1:0]     wr_data,
    output logic [NUM_PARTS-1:0] wr_parity,
    output logic                 out_valid,
    output logic [SEG_W-1:0]     out_data,
    output logic [NUM_PARTS-1:0] out_err,
    output logic [NUM_PARTS-1:0] out_uncorr
);
    rc_mode_e                mode_e;
    logic                    take;
    logic [SEG_W-1:0]        nxt_data;
    logic [NUM_PARTS-1:0]    nxt_err, nxt_unc;

    assign mode_e = rc_mode_e'(mode);
    assign take   = in_valid && (mode_e != RC_OFF);

    rcc_wr_parity #(.NUM_PARTS(NUM_PARTS)) u_wr_parity (
        .data_i (wr_data),
        .par_o  (wr_parity)
    );

    for (genvar k = 0; k < NUM_PARTS; k++) begin : g_part
        rc_result_t res;
        rcc_part_corrector u_corr (
            .mode_i (mode_e),
            .d0_i   (copy0_data[k*PART_W +: PART_W]),
            .d1_i   (copy1_data[k*PART_W +: PART_W]),
            .d2_i   (copy2_data[k*PART_W +: PART_W]),
            .p0_i   (copy0_par[k]),
            .p1_i   (copy1_par[k]),
            .p2_i   (copy2_par[k]),
            .res_o  (res)
        );
        assign nxt_data[k*PART_W +: PART_W] = res.data;
        assign nxt_err[k] = res.err;
        assign nxt_unc[k] = res.unc;
    end

    always_ff @(posedge clk) begin
        if (rst || !take) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_err    <= '0;
            out_uncorr <= '0;
        end else begin
            out_valid  <= 1'b1;
            out_data   <= nxt_data;
            out_err    <= nxt_err;
            out_uncorr <= nxt_unc;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> out_valid == $past(in_valid && mode != 2'd3));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0 && out_err == '0 && out_uncorr == '0));

    // R11
    unc_implies_err_chk: assert property (@(posedge clk) disable iff (rst)
        (out_uncorr & ~out_err) == '0);

    // R3
    single_pass_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && mode == 2'd0) |-> out_data == $past(copy0_data));

    // R4
    double_match_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && mode == 2'd1 && copy0_data == copy1_data)
        |-> (out_data == $past(copy0_data) && out_err == '0));
endmodule

// File: tb/rcc_top_bench.sv
module rcc_top_bench;
    localparam int NP = 4;
    localparam int SW = NP * 16;

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  mode;
        logic [15:0] c0, c1, c2;
        logic [2:0]  p;      // {p2,p1,p0}
        logic [15:0] ed;
        logic        ee, eu, ev;
    } vec_t;

    localparam int NV = 15;
    // 16'h1234 has odd weight (parity 1); 1235 and 1230 fail with parity 1; 1237 passes
    localparam vec_t VECS [NV] = '{
        '{8'd3,  2'd0, 16'h1234, 16'hAAAA, 16'h5555, 3'b001, 16'h1234, 1'b0, 1'b0, 1'b1}, // R3 clean
        '{8'd3,  2'd0, 16'h1235, 16'h1234, 16'h1234, 3'b111, 16'h1235, 1'b1, 1'b1, 1'b1}, // R3 fault
        '{8'd4,  2'd1, 16'h1234, 16'h1234, 16'h00FF, 3'b011, 16'h1234, 1'b0, 1'b0, 1'b1}, // R4 copy2 ignored
        '{8'd5,  2'd1, 16'h1235, 16'h1234, 16'h0000, 3'b011, 16'h1234, 1'b1, 1'b0, 1'b1}, // R5 copy1 good
        '{8'd5,  2'd1, 16'h1234, 16'h1235, 16'h0000, 3'b011, 16'h1234, 1'b1, 1'b0, 1'b1}, // R5 copy0 good
        '{8'd6,  2'd1, 16'h1235, 16'h1230, 16'h1234, 3'b111, 16'h1235, 1'b1, 1'b1, 1'b1}, // R6 both fail
        '{8'd6,  2'd1, 16'h1234, 16'h1237, 16'h1234, 3'b111, 16'h1234, 1'b1, 1'b1, 1'b1}, // R6 both pass
        '{8'd7,  2'd2, 16'h1234, 16'h1234, 16'h1234, 3'b111, 16'h1234, 1'b0, 1'b0, 1'b1}, // R7 clean
        '{8'd7,  2'd2, 16'h1235, 16'h1234, 16'h1234, 3'b111, 16'h1234, 1'b1, 1'b0, 1'b1}, // R7 vote fixes
        '{8'd7,  2'd2, 16'h1234, 16'h1234, 16'h1234, 3'b110, 16'h1234, 1'b1, 1'b0, 1'b1}, // R7 parity vote
        '{8'd8,  2'd2, 16'h1235, 16'h1235, 16'h1234, 3'b111, 16'h1234, 1'b1, 1'b0, 1'b1}, // R8 copy2 only
        '{8'd8,  2'd2, 16'h1235, 16'h1237, 16'h1234, 3'b111, 16'h1237, 1'b1, 1'b0, 1'b1}, // R8 lowest wins
        '{8'd9,  2'd2, 16'h1235, 16'h1235, 16'h1230, 3'b111, 16'h1235, 1'b1, 1'b1, 1'b1}, // R9 none pass
        '{8'd10, 2'd3, 16'h1234, 16'h1234, 16'h1234, 3'b111, 16'h0000, 1'b0, 1'b0, 1'b0}, // R10 disabled
        '{8'd10, 2'd3, 16'h1235, 16'h1230, 16'h1237, 3'b000, 16'h0000, 1'b0, 1'b0, 1'b0}  // R10 disabled
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [SW-1:0] c0d = '0, c1d = '0, c2d = '0, wr_data = '0;
    logic [NP-1:0] c0p = '0, c1p = '0, c2p = '0;
    logic [NP-1:0] wr_parity, out_err, out_uncorr;
    logic          out_valid;
    logic [SW-1:0] out_data;
    int            n_chk = 0, n_bad = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    rcc_top #(.NUM_PARTS(NP)) u_rcc_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .copy0_data(c0d), .copy1_data(c1d), .copy2_data(c2d),
        .copy0_par(c0p), .copy1_par(c1p), .copy2_par(c2p),
        .wr_data(wr_data), .wr_parity(wr_parity),
        .out_valid(out_valid), .out_data(out_data),
        .out_err(out_err), .out_uncorr(out_uncorr)
    );

    task automatic check(input string req, input logic [SW+2*NP:0] act, input logic [SW+2*NP:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R2 reset state
        check("R2", {out_valid, out_data, out_err, out_uncorr}, '0);

        // R11: each vector lands in partition i%NP, other partitions clean zeros
        for (int i = 0; i < NV; i++) begin
            int k = i % NP;
            @(negedge clk);
            in_valid = 1'b1;
            mode = VECS[i].mode;
            c0d = '0; c1d = '0; c2d = '0; c0p = '0; c1p = '0; c2p = '0;
            c0d[k*16 +: 16] = VECS[i].c0;
            c1d[k*16 +: 16] = VECS[i].c1;
            c2d[k*16 +: 16] = VECS[i].c2;
            c0p[k] = VECS[i].p[0];
            c1p[k] = VECS[i].p[1];
            c2p[k] = VECS[i].p[2];
            @(posedge clk);
            #1;
            check($sformatf("R%0d/R11 vec %0d", VECS[i].req, i),
                  {out_valid, out_data, out_err, out_uncorr},
                  {VECS[i].ev, SW'(VECS[i].ed) << (16*k),
                   NP'(VECS[i].ee) << k, NP'(VECS[i].eu) << k});
        end

        // R10: in_valid low with a faulty single-copy read
        @(negedge clk);
        in_valid = 1'b0; mode = 2'd0;
        c0d = {4{16'h1235}}; c0p = '1;
        @(posedge clk);
        #1;
        check("R10 idle", {out_valid, out_data, out_err, out_uncorr}, '0);

        // R11: faults in every partition at once, triple mode, mixed outcomes
        @(negedge clk);
        in_valid = 1'b1; mode = 2'd2;
        c0d = {16'h1235, 16'h1235, 16'h1235, 16'h1234};
        c1d = {16'h1235, 16'h1237, 16'h1234, 16'h1234};
        c2d = {16'h1230, 16'h1234, 16'h1234, 16'h1234};
        c0p = '1; c1p = '1; c2p = '1;
        @(posedge clk);
        #1;
        check("R11 mixed", {out_valid, out_data, out_err, out_uncorr},
              {1'b1, {16'h1235, 16'h1237, 16'h1234, 16'h1234}, 4'b1110, 4'b1000});

        // R1 write parity
        @(negedge clk);
        in_valid = 1'b0;
        wr_data = {16'h1230, 16'h1235, 16'h00FF, 16'h1234};
        #1;
        check("R1", {{(SW+NP+1){1'b0}}, wr_parity}, {{(SW+NP+1){1'b0}}, 4'b0001});
        wr_data = {16'h8000, 16'h1237, 16'h0001, 16'hFFFF};
        #1;
        check("R1", {{(SW+NP+1){1'b0}}, wr_parity}, {{(SW+NP+1){1'b0}}, 4'b1110});

        // R2 reset clears a valid result
        @(negedge clk);
        in_valid = 1'b1; mode = 2'd0; c0d = {4{16'h1235}}; c0p = '1;
        @(posedge clk);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1;
        check("R2 reset", {out_valid, out_data, out_err, out_uncorr}, '0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=finish");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule